// File: doc/BRIEF.md
# Streaming Run Detector and Feature Accumulator

This block watches a binary pixel stream that arrives in raster order, one pixel per clock, with lines packed back to back and no idle gap between them. It detects horizontal runs of set pixels, adds up the pixel count, column-index sum and row-index sum of each run, and reports each finished run as a one-cycle event. The feature sums are enough for a downstream stage to compute a centroid.

To link runs across rows, the block keeps a per-column record of the row above. For each column the record holds whether the pixel was set, whether it began a run, and the provisional label of the run that covered it. Two such records alternate between rows. From the record, the block reports two things without waiting for any blanking interval:
- the first time a current run touches a run above it (four-connectivity: same column, one row up);
- every case where two different runs above are joined by the current run.

Label tables and merging belong to a later stage.

Top module: `stream_run_detector`

## Requirements
- R1: A run begins at a set pixel whose left neighbour in the same line is clear, and closes at the first clear pixel after it. `run_done_o` pulses in the cycle after that clear pixel is accepted, and `run_area_o` equals the number of set pixels in the run.
- R2: A run that reaches the last column of a line closes on the pixel that carries `line_end`, and that pixel is counted in the run. The first pixel of the next line always starts a fresh run, so no run spans two lines.
- R3: With every finished run, the block reports three sums. `run_xsum_o` is the sum of the run's column indices, where columns count from 0 after each line end or frame start. `run_ysum_o` is the run's row index times its area, where rows count from 0 at frame start.
- R4: `run_mode_o` is 2 when any pixel of the run has a set pixel directly above it in the previous row, and 1 otherwise. The first row of a frame has no row above.
- R5: `ovl_hit_o` pulses once per run, in the cycle after the first pixel of the run that has a set pixel above it. `ovl_label_o` then gives the label of the run above at that column.
- R6: `equ_hit_o` pulses in the cycle after a set pixel whose upper neighbour is the first pixel of a run above, provided the current run had already touched a run above at an earlier pixel. `equ_lbl_old_o` gives the label of the last run above touched before that pixel, and `equ_lbl_head_o` gives the label of the run whose first pixel lies above it.
- R7: Runs in a line receive provisional labels 1, 2, 3, … from left to right, with numbering restarting on every line. `run_label_o` reports the label, and the same labels appear on the overlap and equivalence outputs of the following line.
- R8: Every event output is high for exactly one cycle per event, one cycle after the pixel that caused it. A cycle with `pix_vld` low produces no event and advances neither column, row nor sums.
- R9: A pixel flagged `frame_start` is column 0 of row 0. It discards any run left open, and it makes the row above count as empty for the whole first line of the frame.
- R10: After reset, all event outputs are low and all reported values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_vld | input | 1 | Pixel present this cycle |
| pix_bit | input | 1 | Binary pixel value |
| frame_start | input | 1 | Marks the first pixel of a frame |
| line_end | input | 1 | Marks the last pixel of a line |
| run_done_o | output | 1 | Run finished (one-cycle pulse) |
| run_mode_o | output | 2 | 1 = isolated run, 2 = touched a run above |
| run_label_o | output | LBL_W | Provisional label of the finished run |
| run_area_o | output | AREA_W | Pixel count of the run |
| run_xsum_o | output | XS_W | Sum of column indices |
| run_ysum_o | output | YS_W | Sum of row indices |
| ovl_hit_o | output | 1 | First contact of a run with a run above |
| ovl_label_o | output | LBL_W | Label of the touched run above |
| equ_hit_o | output | 1 | Two runs above joined by the current run |
| equ_lbl_old_o | output | LBL_W | Label of the earlier touched run above |
| equ_lbl_head_o | output | LBL_W | Label of the run whose first pixel lies above |

## Verification
An equivalence and a run close can fall in the same cycle. This happens when the last pixel of a line lies under the first pixel of a run above, and the current run had already touched another run above. The bench provokes this with a line whose final run spans two separate runs of the row above, the second of which sits only in the last column. The bench requires the equivalence event and the run event to carry the same pixel position, with the labels, sums and joined mode all correct. First contact and run close on the line-end pixel are likewise provoked with a single-pixel run in the last column.

// File: rtl/srd_pkg.sv
// Shared encodings for the streaming run detector.
package srd_pkg;
    // Position of a pixel relative to runs, from (left neighbour, pixel).
    typedef enum logic [1:0] {
        PX_IDLE  = 2'd0,
        PX_HEAD  = 2'd1,
        PX_BODY  = 2'd2,
        PX_AFTER = 2'd3
    } px_kind_e;

    // Closing mode of a run.
    typedef enum logic [1:0] {
        RM_NONE   = 2'd0,
        RM_ALONE  = 2'd1,
        RM_JOINED = 2'd2
    } run_mode_e;
endpackage

// File: rtl/srd_classifier.sv
// Pixel classifier and raster position tracker.
// Classifies each accepted pixel from the pair (left neighbour, pixel) and
// keeps the column and row counters. Assumes frame_start and line_end come
// only with a valid pixel. The left neighbour is forced clear at line and
// frame start, so a run closes on the line-end pixel at the latest.
module srd_classifier
    import srd_pkg::*;
#(
    parameter int COL_W = 6,
    parameter int ROW_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_vld,
    input  logic             pix_bit,
    input  logic             sof,
    input  logic             eol,
    output px_kind_e         kind,
    output logic             close_now,
    output logic             close_incl,
    output logic             above_ok,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row
);
    logic             left_q;
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;
    logic             have_above_q;
    logic             left_eff;

    // Effective position and neighbour, with frame start overriding state.
    always_comb begin
        left_eff = sof ? 1'b0 : left_q;
        col      = sof ? '0 : col_q;
        row      = sof ? '0 : row_q;
        above_ok = !sof && have_above_q;
    end

    // Classify the pixel and detect run closes (real or virtual).
    always_comb begin
        case ({left_eff, pix_bit})
            2'b01:   kind = PX_HEAD;
            2'b11:   kind = PX_BODY;
            2'b10:   kind = PX_AFTER;
            default: kind = PX_IDLE;
        endcase
        close_now  = pix_vld && ((left_eff && !pix_bit) || (pix_bit && eol));
        close_incl = pix_vld && pix_bit && eol;
    end

    // Advance the left neighbour and raster counters on accepted pixels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q       <= 1'b0;
            col_q        <= '0;
            row_q        <= '0;
            have_above_q <= 1'b0;
        end else if (pix_vld) begin
            left_q       <= eol ? 1'b0 : pix_bit;
            col_q        <= eol ? '0 : col + 1'b1;
            row_q        <= eol ? row + 1'b1 : row;
            have_above_q <= eol ? 1'b1 : above_ok;
        end
    end
endmodule

// File: rtl/srd_row_record.sv
// Ping-pong per-column record of the previous row.
// One bank is read as the row above while the other collects the current
// row. Occupancy and head bits are written per pixel. The label field is
// written over a column range when a run closes. Banks swap on line end.
module srd_row_record #(
    parameter int COLS  = 64,
    parameter int COL_W = 6,
    parameter int LBL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             swap,
    input  logic             wr_en,
    input  logic [COL_W-1:0] wr_col,
    input  logic             wr_g,
    input  logic             wr_head,
    input  logic             lbl_we,
    input  logic [COL_W-1:0] lbl_lo,
    input  logic [COL_W-1:0] lbl_hi,
    input  logic [LBL_W-1:0] lbl_val,
    input  logic [COL_W-1:0] rd_col,
    output logic             rd_g,
    output logic             rd_head,
    output logic [LBL_W-1:0] rd_lbl
);
    logic             rd_sel;
    logic [COLS-1:0]  g_vec    [2];
    logic [COLS-1:0]  head_vec [2];
    logic [LBL_W-1:0] lbl_vec  [2][COLS];

    // Select which bank holds the row above; flip at each line end.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_sel <= 1'b0;
        else if (swap) rd_sel <= ~rd_sel;
    end

    for (genvar b = 0; b < 2; b++) begin : g_bank
        for (genvar c = 0; c < COLS; c++) begin : g_col
            logic             g_q;
            logic             head_q;
            logic [LBL_W-1:0] lbl_q;
            logic             bank_wr;

            assign bank_wr = (rd_sel != 1'(b));

            // Per-pixel occupancy/head update and ranged label write-back.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    g_q    <= 1'b0;
                    head_q <= 1'b0;
                    lbl_q  <= '0;
                end else if (bank_wr) begin
                    if (wr_en && wr_col == COL_W'(c)) begin
                        g_q    <= wr_g;
                        head_q <= wr_head;
                    end
                    if (lbl_we && COL_W'(c) >= lbl_lo && COL_W'(c) <= lbl_hi)
                        lbl_q <= lbl_val;
                end
            end

            assign g_vec[b][c]    = g_q;
            assign head_vec[b][c] = head_q;
            assign lbl_vec[b][c]  = lbl_q;
        end
    end

    // Read the row-above bank at the current column.
    always_comb begin
        rd_g    = g_vec[rd_sel][rd_col];
        rd_head = head_vec[rd_sel][rd_col];
        rd_lbl  = lbl_vec[rd_sel][rd_col];
    end
endmodule

// File: rtl/srd_accum.sv
// Per-run feature accumulator: pixel count, column sum, row sum.
// Presents the sums including the current pixel and clears them on the
// cycle a run closes. Frame start discards any partial sums.
module srd_accum #(
    parameter int COL_W  = 6,
    parameter int ROW_W  = 6,
    parameter int AREA_W = 7,
    parameter int XS_W   = 12,
    parameter int YS_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_vld,
    input  logic              pix_bit,
    input  logic              restart,
    input  logic              close,
    input  logic [COL_W-1:0]  col,
    input  logic [ROW_W-1:0]  row,
    output logic [AREA_W-1:0] area_sum,
    output logic [XS_W-1:0]   xs_sum,
    output logic [YS_W-1:0]   ys_sum
);
    logic [AREA_W-1:0] area_q;
    logic [XS_W-1:0]   xs_q;
    logic [YS_W-1:0]   ys_q;
    logic              add;

    // Running sums including this pixel's contribution.
    always_comb begin
        add      = pix_vld && pix_bit;
        area_sum = (restart ? '0 : area_q) + AREA_W'(add);
        xs_sum   = (restart ? '0 : xs_q) + (add ? XS_W'(col) : '0);
        ys_sum   = (restart ? '0 : ys_q) + (add ? YS_W'(row) : '0);
    end

    // Hold the partial sums, or clear them when the run closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            area_q <= '0;
            xs_q   <= '0;
            ys_q   <= '0;
        end else if (pix_vld) begin
            area_q <= close ? '0 : area_sum;
            xs_q   <= close ? '0 : xs_sum;
            ys_q   <= close ? '0 : ys_sum;
        end
    end
endmodule

// File: rtl/stream_run_detector.sv
// Streaming run detector and feature accumulator (top).
// Accepts one binary pixel per valid cycle in raster order with no line
// gap. Reports run closes with sums and mode, first contact with a run in
// the row above, and joins of two runs above, all one cycle after the
// causing pixel. Assumes every line of a frame carries COLS pixels.
module stream_run_detector
    import srd_pkg::*;
#(
    parameter  int COLS   = 64,
    parameter  int ROWS   = 48,
    localparam int COL_W  = $clog2(COLS),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int LBL_W  = $clog2(COLS / 2 + 2),
    localparam int AREA_W = $clog2(COLS + 1),
    localparam int XS_W   = $clog2(COLS * COLS),
    localparam int YS_W   = $clog2(COLS * ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_vld,
    input  logic              pix_bit,
    input  logic              frame_start,
    input  logic              line_end,
    output logic              run_done_o,
    output logic [1:0]        run_mode_o,
    output logic [LBL_W-1:0]  run_label_o,
    output logic [AREA_W-1:0] run_area_o,
    output logic [XS_W-1:0]   run_xsum_o,
    output logic [YS_W-1:0]   run_ysum_o,
    output logic              ovl_hit_o,
    output logic [LBL_W-1:0]  ovl_label_o,
    output logic              equ_hit_o,
    output logic [LBL_W-1:0]  equ_lbl_old_o,
    output logic [LBL_W-1:0]  equ_lbl_head_o
);
    px_kind_e          kind;
    logic              close_now, close_incl, above_ok;
    logic [COL_W-1:0]  col;
    logic [ROW_W-1:0]  row;
    logic              rd_g, rd_head;
    logic [LBL_W-1:0]  rd_lbl;
    logic [AREA_W-1:0] area_sum;
    logic [XS_W-1:0]   xs_sum;
    logic [YS_W-1:0]   ys_sum;

    logic              run_ovl_q;
    logic [LBL_W-1:0]  last_lbl_q;
    logic [COL_W-1:0]  x0_q;
    logic [LBL_W-1:0]  lbl_cnt_q;

    logic              in_run, up_g, up_head, ovl_now, ovl_seen;
    logic              equ_now, first_ovl, is_head;
    logic [LBL_W-1:0]  lbl_cur;
    logic [COL_W-1:0]  x0_cur, lbl_hi;

    srd_classifier #(.COL_W(COL_W), .ROW_W(ROW_W)) u_cls (
        .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_bit(pix_bit),
        .sof(frame_start), .eol(line_end), .kind(kind),
        .close_now(close_now), .close_incl(close_incl),
        .above_ok(above_ok), .col(col), .row(row)
    );

    srd_row_record #(.COLS(COLS), .COL_W(COL_W), .LBL_W(LBL_W)) u_rec (
        .clk(clk), .rst_n(rst_n), .swap(pix_vld && line_end),
        .wr_en(pix_vld), .wr_col(col), .wr_g(pix_bit), .wr_head(is_head),
        .lbl_we(close_now), .lbl_lo(x0_cur), .lbl_hi(lbl_hi),
        .lbl_val(lbl_cur), .rd_col(col), .rd_g(rd_g), .rd_head(rd_head),
        .rd_lbl(rd_lbl)
    );

    srd_accum #(
        .COL_W(COL_W), .ROW_W(ROW_W), .AREA_W(AREA_W), .XS_W(XS_W), .YS_W(YS_W)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_bit(pix_bit),
        .restart(frame_start), .close(close_now), .col(col), .row(row),
        .area_sum(area_sum), .xs_sum(xs_sum), .ys_sum(ys_sum)
    );

    // Contact, equivalence and labelling decisions for the current pixel.
    always_comb begin
        is_head   = (kind == PX_HEAD);
        in_run    = pix_vld && pix_bit;
        up_g      = above_ok && rd_g;
        up_head   = above_ok && rd_head;
        ovl_seen  = frame_start ? 1'b0 : run_ovl_q;
        ovl_now   = in_run && up_g;
        equ_now   = in_run && up_head && ovl_seen;
        first_ovl = ovl_now && !ovl_seen;
        lbl_cur   = frame_start ? LBL_W'(1) : lbl_cnt_q;
        x0_cur    = is_head ? col : x0_q;
        lbl_hi    = close_incl ? col : col - 1'b1;
    end

    // Per-run context: contact flag, last touched label, start column, label counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_ovl_q  <= 1'b0;
            last_lbl_q <= '0;
            x0_q       <= '0;
            lbl_cnt_q  <= LBL_W'(1);
        end else if (pix_vld) begin
            run_ovl_q <= close_now ? 1'b0 : (ovl_seen || ovl_now);
            if (ovl_now) last_lbl_q <= rd_lbl;
            if (is_head) x0_q <= col;
            lbl_cnt_q <= line_end ? LBL_W'(1)
                       : (close_now ? lbl_cur + 1'b1 : lbl_cur);
        end
    end

    // Registered event pulses and their payloads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_done_o     <= 1'b0;
            run_mode_o     <= RM_NONE;
            run_label_o    <= '0;
            run_area_o     <= '0;
            run_xsum_o     <= '0;
            run_ysum_o     <= '0;
            ovl_hit_o      <= 1'b0;
            ovl_label_o    <= '0;
            equ_hit_o      <= 1'b0;
            equ_lbl_old_o  <= '0;
            equ_lbl_head_o <= '0;
        end else begin
            run_done_o <= close_now;
            ovl_hit_o  <= first_ovl;
            equ_hit_o  <= equ_now;
            if (close_now) begin
                run_mode_o  <= (ovl_seen || ovl_now) ? RM_JOINED : RM_ALONE;
                run_label_o <= lbl_cur;
                run_area_o  <= area_sum;
                run_xsum_o  <= xs_sum;
                run_ysum_o  <= ys_sum;
            end
            if (first_ovl) ovl_label_o <= rd_lbl;
            if (equ_now) begin
                equ_lbl_old_o  <= last_lbl_q;
                equ_lbl_head_o <= rd_lbl;
            end
        end
    end
endmodule

// File: rtl/srd_checker.sv
// Property checker for stream_run_detector, attached by bind.
module srd_checker #(
    parameter  int COLS   = 64,
    localparam int LBL_W  = $clog2(COLS / 2 + 2),
    localparam int AREA_W = $clog2(COLS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_vld,
    input logic              pix_bit,
    input logic              frame_start,
    input logic              run_done_o,
    input logic [1:0]        run_mode_o,
    input logic [AREA_W-1:0] run_area_o,
    input logic              ovl_hit_o,
    input logic              equ_hit_o,
    input logic [LBL_W-1:0]  equ_lbl_old_o,
    input logic [LBL_W-1:0]  equ_lbl_head_o
);
    // R8
    idle_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_vld |=> (!run_done_o && !ovl_hit_o && !equ_hit_o));

    // R4
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_done_o |-> (run_mode_o == 2'd1 || run_mode_o == 2'd2));

    // R1
    area_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_done_o |-> (run_area_o != '0 && run_area_o <= AREA_W'(COLS)));

    // R6
    equ_no_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(equ_hit_o && ovl_hit_o));

    // R6
    equ_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        equ_hit_o |-> (equ_lbl_old_o != equ_lbl_head_o));

    // R5
    contact_joined_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_hit_o && run_done_o) |-> (run_mode_o == 2'd2));

    // R9
    first_pix_no_contact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld && frame_start && pix_bit) |=> (!ovl_hit_o && !equ_hit_o));
endmodule

bind stream_run_detector srd_checker #(.COLS(COLS)) u_srd_chk (
    .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_bit(pix_bit),
    .frame_start(frame_start), .run_done_o(run_done_o),
    .run_mode_o(run_mode_o), .run_area_o(run_area_o),
    .ovl_hit_o(ovl_hit_o), .equ_hit_o(equ_hit_o),
    .equ_lbl_old_o(equ_lbl_old_o), .equ_lbl_head_o(equ_lbl_head_o)
);

// File: tb/tb_stream_run_detector.sv
`timescale 1ns/1ps
module tb_stream_run_detector;
    localparam int COLS   = 16;
    localparam int ROWS   = 8;
    localparam int LBL_W  = $clog2(COLS / 2 + 2);
    localparam int AREA_W = $clog2(COLS + 1);
    localparam int XS_W   = $clog2(COLS * COLS);
    localparam int YS_W   = $clog2(COLS * ROWS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_vld = 1'b0, pix_bit = 1'b0, frame_start = 1'b0, line_end = 1'b0;
    logic              run_done_o;
    logic [1:0]        run_mode_o;
    logic [LBL_W-1:0]  run_label_o;
    logic [AREA_W-1:0] run_area_o;
    logic [XS_W-1:0]   run_xsum_o;
    logic [YS_W-1:0]   run_ysum_o;
    logic              ovl_hit_o;
    logic [LBL_W-1:0]  ovl_label_o;
    logic              equ_hit_o;
    logic [LBL_W-1:0]  equ_lbl_old_o, equ_lbl_head_o;

    always #2 clk = ~clk;

    stream_run_detector #(.COLS(COLS), .ROWS(ROWS)) dut (
        .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_bit(pix_bit),
        .frame_start(frame_start), .line_end(line_end),
        .run_done_o(run_done_o), .run_mode_o(run_mode_o),
        .run_label_o(run_label_o), .run_area_o(run_area_o),
        .run_xsum_o(run_xsum_o), .run_ysum_o(run_ysum_o),
        .ovl_hit_o(ovl_hit_o), .ovl_label_o(ovl_label_o),
        .equ_hit_o(equ_hit_o), .equ_lbl_old_o(equ_lbl_old_o),
        .equ_lbl_head_o(equ_lbl_head_o)
    );

    int n_checks = 0, n_errors = 0;
    int drv_col = 0, drv_row = 0;

    // Event logs; each entry tagged with the column/row of the causing pixel.
    int r_n = 0, o_n = 0, e_n = 0;
    int r_area[64], r_xs[64], r_ys[64], r_mode[64], r_lbl[64], r_col[64], r_row[64];
    int o_lbl[64], o_col[64];
    int e_a[64], e_b[64], e_col[64];

    always @(posedge clk) begin
        #1;
        if (run_done_o && r_n < 64) begin
            r_area[r_n] = int'(run_area_o); r_xs[r_n] = int'(run_xsum_o);
            r_ys[r_n] = int'(run_ysum_o); r_mode[r_n] = int'(run_mode_o);
            r_lbl[r_n] = int'(run_label_o); r_col[r_n] = drv_col;
            r_row[r_n] = drv_row; r_n++;
        end
        if (ovl_hit_o && o_n < 64) begin
            o_lbl[o_n] = int'(ovl_label_o); o_col[o_n] = drv_col; o_n++;
        end
        if (equ_hit_o && e_n < 64) begin
            e_a[e_n] = int'(equ_lbl_old_o); e_b[e_n] = int'(equ_lbl_head_o);
            e_col[e_n] = drv_col; e_n++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] span(input int lo, input int hi);
        logic [15:0] m = '0;
        for (int i = lo; i <= hi; i++) m[i] = 1'b1;
        return m;
    endfunction

    task automatic put_pix(input logic p, input logic s, input logic e, input int c, input int r);
        @(negedge clk);
        pix_vld = 1'b1; pix_bit = p; frame_start = s; line_end = e;
        drv_col = c; drv_row = r;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pix_vld = 1'b0; pix_bit = 1'b0; frame_start = 1'b0; line_end = 1'b0;
        end
    endtask

    task automatic drive_line(input logic [15:0] bits, input int r, input logic sof);
        for (int c = 0; c < COLS; c++)
            put_pix(bits[c], sof && c == 0, c == COLS - 1, c, r);
    endtask

    task automatic expect_run(input string req, input int i, input int area, input int xs,
                              input int ys, input int mode, input int lbl, input int col);
        chk(req, "run area", r_area[i], area);
        chk(req, "run column sum", r_xs[i], xs);
        chk(req, "run row sum", r_ys[i], ys);
        chk(req, "run mode", r_mode[i], mode);
        chk(req, "run label", r_lbl[i], lbl);
        chk(req, "run event column", r_col[i], col);
    endtask

    // R10: reset state of every output.
    task automatic t_reset;
        chk("R10", "run_done", int'(run_done_o), 0);
        chk("R10", "ovl_hit", int'(ovl_hit_o), 0);
        chk("R10", "equ_hit", int'(equ_hit_o), 0);
        chk("R10", "area", int'(run_area_o), 0);
        chk("R10", "mode", int'(run_mode_o), 0);
    endtask

    // R1 R3 R7 R8: two runs on the first row of a frame.
    task automatic t_first_row;
        int rb = r_n;
        drive_line(span(1, 3) | span(8, 9), 0, 1'b1);
        idle(3);
        chk("R1", "run count", r_n - rb, 2);
        expect_run("R1", rb, 3, 6, 0, 1, 1, 4);
        expect_run("R7", rb + 1, 2, 17, 0, 1, 2, 10);
    endtask

    // R2 R4 R5: run to last column, then a new line that starts set.
    task automatic t_line_edge;
        int rb = r_n, ob = o_n;
        drive_line(span(13, 15), 0, 1'b1);
        drive_line(span(0, 0) | span(15, 15), 1, 1'b0);
        idle(3);
        chk("R2", "run count", r_n - rb, 3);
        expect_run("R2", rb, 3, 42, 0, 1, 1, 15);
        expect_run("R2", rb + 1, 1, 0, 1, 1, 1, 1);
        expect_run("R4", rb + 2, 1, 15, 1, 2, 2, 15);
        chk("R5", "contact count", o_n - ob, 1);
        chk("R5", "contact label", o_lbl[ob], 1);
        chk("R5", "contact column", o_col[ob], 15);
    endtask

    // R6: a run that spans two runs of the row above.
    task automatic t_join;
        int rb = r_n, ob = o_n, eb = e_n;
        drive_line(span(2, 3) | span(6, 7), 0, 1'b1);
        drive_line(span(1, 8), 1, 1'b0);
        idle(3);
        chk("R6", "run count", r_n - rb, 3);
        expect_run("R4", rb + 2, 8, 36, 8, 2, 1, 9);
        chk("R5", "contact count", o_n - ob, 1);
        chk("R5", "contact label", o_lbl[ob], 1);
        chk("R5", "contact column", o_col[ob], 2);
        chk("R6", "equ count", e_n - eb, 1);
        chk("R6", "equ old label", e_a[eb], 1);
        chk("R6", "equ head label", e_b[eb], 2);
        chk("R6", "equ column", e_col[eb], 6);
    endtask

    // R5 R6: contact at a head with no earlier contact, and contact mid-run.
    task automatic t_no_join;
        int rb = r_n, ob = o_n, eb = e_n;
        drive_line(span(0, 7) | span(10, 11), 0, 1'b1);
        drive_line(span(3, 4) | span(10, 11), 1, 1'b0);
        idle(3);
        chk("R6", "equ count", e_n - eb, 0);
        chk("R5", "contact count", o_n - ob, 2);
        chk("R5", "first contact label", o_lbl[ob], 1);
        chk("R5", "first contact column", o_col[ob], 3);
        chk("R5", "second contact label", o_lbl[ob + 1], 2);
        chk("R5", "second contact column", o_col[ob + 1], 10);
        expect_run("R7", rb + 2, 2, 7, 2, 2, 1, 5);
        expect_run("R7", rb + 3, 2, 21, 2, 2, 2, 12);
    endtask

    // R6 R2: equivalence and run close in the same cycle at line end.
    task automatic t_same_cycle;
        int rb = r_n, eb = e_n;
        drive_line(span(10, 11) | span(15, 15), 0, 1'b1);
        drive_line(span(10, 15), 1, 1'b0);
        idle(3);
        chk("R6", "equ count", e_n - eb, 1);
        chk("R6", "equ old label", e_a[eb], 1);
        chk("R6", "equ head label", e_b[eb], 2);
        chk("R6", "equ column", e_col[eb], 15);
        expect_run("R2", rb + 2, 6, 75, 6, 2, 1, 15);
    endtask

    // R8: idle cycles between pixels change nothing.
    task automatic t_gaps;
        int rb = r_n;
        logic [15:0] bits = span(2, 4);
        for (int c = 0; c < COLS; c++) begin
            put_pix(bits[c], c == 0, c == COLS - 1, c, 0);
            idle(2);
        end
        idle(2);
        chk("R8", "run count", r_n - rb, 1);
        expect_run("R8", rb, 3, 9, 0, 1, 1, 5);
    endtask

    // R9: frame start drops an open run and hides the previous row.
    task automatic t_frame_restart;
        int rb = r_n, ob = o_n;
        logic [15:0] part = span(4, 5);
        drive_line(span(0, 15), 0, 1'b1);
        for (int c = 0; c < 6; c++) put_pix(part[c], 1'b0, 1'b0, c, 1);
        drive_line(span(5, 6), 0, 1'b1);
        idle(3);
        chk("R9", "run count", r_n - rb, 2);
        expect_run("R3", rb, 16, 120, 0, 1, 1, 15);
        expect_run("R9", rb + 1, 2, 11, 0, 1, 1, 7);
        chk("R9", "contact count", o_n - ob, 1);
    endtask

    initial begin
        #(4 * 100000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_row();
        t_line_edge();
        t_join();
        t_no_join();
        t_same_cycle();
        t_gaps();
        t_frame_restart();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule